// File: doc/BRIEF.md
# Dual-Slot Conditional-Access Module Control and Status Register

This block is the control and status register for a host adapter with two common-interface module slots. The host sees one 16-bit word through two bus addresses. A write to the set address turns on every bit that is 1 in the data. A write to the clear address turns off every bit that is 1 in the data. A read at either address returns the live word. Each slot owns one byte lane of the word. The lane holds the following bits:

- a status-change flag
- read-only mirrors of the card-detect, ready, error and over-current inputs
- a self-timed reset request
- a bypass control that steers the transport stream around the module

A status change in either slot can raise a host interrupt. A global enable bit gates that interrupt, and the host acknowledges it by clearing the status-change flags through the clear address.

For each slot the block drives a reset pulse of fixed length and a bypass level. It also decodes a two-bit presence code that software can use in place of reading the raw bits. The slot inputs are treated as already synchronous to the register clock.

Top module: `cam_ctrl_regs`

## Requirements
- R1: A write with `bus_we` high to byte address 0x4980 (set port) sets every register bit whose data bit is 1. A write to 0x4982 (clear port) clears every such bit. Zero data bits leave bits unchanged. A read at either port returns the register word on `bus_rdata` in the same cycle. Any other address reads 0 and writes there change nothing.
- R2: Slot 0 occupies bits 6:0 and slot 1 occupies bits 14:8, with the same layout in each lane:
  - bit 0: status change
  - bit 1: module present
  - bit 2: reset
  - bit 3: bypass
  - bit 4: ready
  - bit 5: error
  - bit 6: over-current

  Bit 7 is the interrupt enable. Bit 15 always reads 0.
- R3: The bypass bit of a slot drives `slot_bypass` for that slot. It changes only through the set and clear ports.
- R4: Setting a slot's reset bit drives `slot_reset` high for exactly RST_CYCLES (default 4) clock cycles, starting after the write edge. The reset bit reads 1 for the same cycles and then clears itself. A new set restarts the count. Writing 1 to the reset bit through the clear port ends the pulse at once.
- R5: The ready bit reads 0 while a reset pulse is active and in the cycle the pulse starts. Otherwise it shows the slot ready input as it was at the previous clock edge, so it first reads 1 one cycle after the pulse ends.
- R6: The present, error and over-current bits show their inputs as they were at the previous clock edge. Writes to these bits through either port, and writes to the ready bit, have no effect.
- R7: Any change on a slot's present, ready, error or over-current input sets that slot's status-change bit one cycle later. The bit stays set until the clear port clears it. An input change in the same cycle as the clear keeps the bit set. The set port cannot set it.
- R8: `irq` is high when the enable bit is 1 and either status-change bit is 1. Writing 0x0101 to the clear port drops `irq`, provided no new input change arrives in that cycle.
- R9: `slot_status` holds a 2-bit code per slot, with slot 0 in bits 1:0 and slot 1 in bits 3:2:
  - 2'b11 when the ready bit is 1
  - otherwise 2'b01 when the present bit is 1
  - otherwise 2'b00
- R10: After reset with all slot inputs low, the word reads 0x0808 and both slots are in bypass. Reset, status change and interrupt enable are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed port |
| bus_addr | input | 16 | Byte address of the access |
| bus_wdata | input | 16 | Write data (mask of bits to set or clear) |
| bus_rdata | output | 16 | Register word when a port is addressed, else 0 |
| slot_present | input | 2 | Card-detect per slot |
| slot_ready | input | 2 | Module ready per slot |
| slot_error | input | 2 | Module error per slot |
| slot_ovc | input | 2 | Over-current flag per slot |
| slot_reset | output | 2 | Module reset pulse per slot |
| slot_bypass | output | 2 | Transport-stream bypass per slot |
| slot_status | output | 4 | Presence code per slot (R9) |
| irq | output | 1 | Status-change interrupt to the host |

## Verification
Two pairs of functions can land in the same cycle:

- A slot input changes on the same edge as a clear-port write that acknowledges the status-change flag.
- A reset request is written while the ready input is already high.

Directed sequences force each collision deliberately. The check confirms that the flag survives the clear, and that ready stays hidden until one cycle after the pulse ends. A cycle-accurate bench model then runs random input toggles against random set and clear writes, which also produces restarts and aborts of running pulses. Every cycle it compares the word, the outputs and the interrupt.

// File: rtl/cam_regs_pkg.sv
package cam_regs_pkg;

  localparam int unsigned LANE_W     = 8;
  localparam int unsigned IRQ_EN_BIT = 7;

  // Lane layout, bit 6 down to bit 0
  typedef struct packed {
    logic ovc;
    logic err;
    logic rdy;
    logic byp;
    logic rst;
    logic pres;
    logic chg;
  } lane_bits_t;

  localparam int unsigned LANE_USED = $bits(lane_bits_t);

  typedef struct packed {
    logic ovc;
    logic err;
    logic rdy;
    logic pres;
  } slot_in_t;

  typedef enum logic [1:0] {
    ST_NONE    = 2'b00,
    ST_PRESENT = 2'b01,
    ST_READY   = 2'b11
  } slot_state_e;

endpackage

// File: rtl/cam_rst_sync.sv
module cam_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/cam_slot_lane.sv
module cam_slot_lane
  import cam_regs_pkg::*;
#(
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  lane_bits_t  set_i,
  input  lane_bits_t  clr_i,
  input  logic        in_pres,
  input  logic        in_rdy,
  input  logic        in_err,
  input  logic        in_ovc,
  output lane_bits_t  lane_o,
  output logic        rst_o,
  output logic        byp_o,
  output logic [1:0]  status_o
);

  localparam int unsigned    CNT_W    = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RST_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  slot_in_t          cur;
  slot_in_t          prev_q, prev_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en;
  logic              byp_q, byp_d, byp_en;
  logic              rdy_q, rdy_d;
  logic              chg_q, chg_d;
  logic              evt;
  logic              pulse_on;

  assign cur      = '{ovc: in_ovc, err: in_err, rdy: in_rdy, pres: in_pres};
  assign pulse_on = (cnt_q != '0);

  // Next-state logic
  always_comb begin
    prev_d = cur;
    evt    = |(cur ^ prev_q);

    // Reset pulse counter: start wins, abort next, then count down
    cnt_en = 1'b1;
    if (set_i.rst) begin
      cnt_d = CNT_LOAD;
    end else if (clr_i.rst) begin
      cnt_d = '0;
    end else if (pulse_on) begin
      cnt_d = cnt_q - CNT_ONE;
    end else begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
    end

    // Bypass control
    byp_en = set_i.byp | clr_i.byp;
    byp_d  = set_i.byp;

    // Ready is qualified by the absence of a pulse
    rdy_d = in_rdy & ~pulse_on & ~set_i.rst;

    // Sticky status change; a new event beats the clear
    chg_d = evt | (chg_q & ~clr_i.chg);
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      cnt_q  <= '0;
      byp_q  <= 1'b1;
      rdy_q  <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      prev_q <= prev_d;
      if (cnt_en) cnt_q <= cnt_d;
      if (byp_en) byp_q <= byp_d;
      rdy_q  <= rdy_d;
      chg_q  <= chg_d;
    end
  end

  always_comb begin
    lane_o      = '0;
    lane_o.ovc  = prev_q.ovc;
    lane_o.err  = prev_q.err;
    lane_o.rdy  = rdy_q;
    lane_o.byp  = byp_q;
    lane_o.rst  = pulse_on;
    lane_o.pres = prev_q.pres;
    lane_o.chg  = chg_q;
  end

  assign rst_o = pulse_on;
  assign byp_o = byp_q;

  always_comb begin
    if (rdy_q)            status_o = ST_READY;
    else if (prev_q.pres) status_o = ST_PRESENT;
    else                  status_o = ST_NONE;
  end

  // Assertions
  assert_pulse_ends_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_o && cnt_q == CNT_ONE && !set_i.rst && !clr_i.rst) |=> !rst_o);

  assert_pulse_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_o) |-> $past(set_i.rst));

  assert_ready_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lane_o.rdy |-> !rst_o);

  assert_bypass_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i.byp && !clr_i.byp) |=> $stable(byp_o));

  assert_change_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_o.chg && !clr_i.chg) |=> lane_o.chg);

  assert_change_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pres != lane_o.pres || in_err != lane_o.err || in_ovc != lane_o.ovc)
      |=> lane_o.chg);

  assert_set_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i.chg && !lane_o.chg && $stable(in_pres) && $stable(in_rdy)
     && $stable(in_err) && $stable(in_ovc)) |=> !lane_o.chg);

  assert_mirror_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i.pres || set_i.err || set_i.ovc || set_i.rdy ||
     clr_i.pres || clr_i.err || clr_i.ovc || clr_i.rdy)
      |=> (lane_o.pres == $past(in_pres) && lane_o.err == $past(in_err)
           && lane_o.ovc == $past(in_ovc)));

endmodule

// File: rtl/cam_irq_gen.sv
module cam_irq_gen #(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_set,
  input  logic               en_clr,
  input  logic [NUM_SRC-1:0] chg_vec,
  output logic               en_o,
  output logic               irq_o
);

  logic en_q, en_d, en_we;

  always_comb begin
    en_we = en_set | en_clr;
    en_d  = en_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      if (en_we) en_q <= en_d;
    end
  end

  assign en_o  = en_q;
  assign irq_o = en_q & (|chg_vec);

  assert_mask_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr && !en_set) |=> !irq_o);

  assert_irq_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (|chg_vec));

endmodule

// File: rtl/cam_ctrl_regs.sv
module cam_ctrl_regs
  import cam_regs_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 16,
  parameter logic [ADDR_W-1:0] SET_OFS = ADDR_W'('h4980),
  parameter logic [ADDR_W-1:0] CLR_OFS = ADDR_W'('h4982),
  parameter int unsigned RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [1:0]        slot_present,
  input  logic [1:0]        slot_ready,
  input  logic [1:0]        slot_error,
  input  logic [1:0]        slot_ovc,
  output logic [1:0]        slot_reset,
  output logic [1:0]        slot_bypass,
  output logic [3:0]        slot_status,
  output logic              irq
);

  localparam int unsigned NUM_SLOTS = DATA_W / LANE_W;

  logic                 rst_i_n;
  logic                 hit_set, hit_clr, hit_any;
  logic [DATA_W-1:0]    set_vec, clr_vec;
  logic [DATA_W-1:0]    word;
  logic [NUM_SLOTS-1:0] chg_vec;
  logic [NUM_SLOTS-1:0] rsv_wr, rsv_rd;
  logic                 irq_en;

  cam_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Address decode
  always_comb begin
    hit_set = (bus_addr == SET_OFS);
    hit_clr = (bus_addr == CLR_OFS);
    hit_any = hit_set | hit_clr;
    set_vec = (bus_we && hit_set) ? bus_wdata : '0;
    clr_vec = (bus_we && hit_clr) ? bus_wdata : '0;
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_lane
    lane_bits_t lane_set, lane_clr, lane_val;
    logic [1:0] lane_st;
    logic       lane_rst, lane_byp;

    assign lane_set = lane_bits_t'(set_vec[s*LANE_W +: LANE_USED]);
    assign lane_clr = lane_bits_t'(clr_vec[s*LANE_W +: LANE_USED]);

    cam_slot_lane #(.RST_CYCLES(RST_CYCLES)) u_lane (
      .clk      (clk),
      .rst_n    (rst_i_n),
      .set_i    (lane_set),
      .clr_i    (lane_clr),
      .in_pres  (slot_present[s]),
      .in_rdy   (slot_ready[s]),
      .in_err   (slot_error[s]),
      .in_ovc   (slot_ovc[s]),
      .lane_o   (lane_val),
      .rst_o    (lane_rst),
      .byp_o    (lane_byp),
      .status_o (lane_st)
    );

    assign word[s*LANE_W +: LANE_USED] = lane_val;
    assign chg_vec[s]                  = lane_val.chg;
    assign slot_reset[s]               = lane_rst;
    assign slot_bypass[s]              = lane_byp;
    assign slot_status[2*s +: 2]       = lane_st;

    if (s == 0) begin : g_en_bit
      assign word[s*LANE_W + IRQ_EN_BIT] = irq_en;
      assign rsv_wr[s] = 1'b0;
      assign rsv_rd[s] = 1'b0;
    end else begin : g_rsv_bit
      assign word[s*LANE_W + IRQ_EN_BIT] = 1'b0;
      assign rsv_wr[s] = set_vec[s*LANE_W + IRQ_EN_BIT] | clr_vec[s*LANE_W + IRQ_EN_BIT];
      assign rsv_rd[s] = word[s*LANE_W + IRQ_EN_BIT];
    end
  end

  cam_irq_gen #(.NUM_SRC(NUM_SLOTS)) u_irq (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .en_set  (set_vec[IRQ_EN_BIT]),
    .en_clr  (clr_vec[IRQ_EN_BIT]),
    .chg_vec (chg_vec),
    .en_o    (irq_en),
    .irq_o   (irq)
  );

  assign bus_rdata = hit_any ? word : '0;

  assert_reserved_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    (|rsv_wr) |=> !(|rsv_rd));

  assert_other_addr_R1: assert property (@(posedge clk) disable iff (!rst_i_n)
    !hit_any |-> (bus_rdata == '0));

endmodule

// File: tb/tb_cam_ctrl_regs.sv
`timescale 1ns/1ps
module tb_cam_ctrl_regs;

  localparam logic [15:0] SET_A = 16'h4980;
  localparam logic [15:0] CLR_A = 16'h4982;
  localparam logic [15:0] OTH_A = 16'h4984;
  localparam int RST_N_CYC = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic [1:0]  slot_present, slot_ready, slot_error, slot_ovc;
  logic [1:0]  slot_reset, slot_bypass;
  logic [3:0]  slot_status;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  cam_ctrl_regs #(.RST_CYCLES(RST_N_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .slot_present(slot_present), .slot_ready(slot_ready),
    .slot_error(slot_error), .slot_ovc(slot_ovc),
    .slot_reset(slot_reset), .slot_bypass(slot_bypass),
    .slot_status(slot_status), .irq(irq)
  );

  always #10 clk = ~clk;

  // Reference model, updated on each rising edge from the requirements
  int         m_cnt  [2];
  logic       m_byp  [2];
  logic       m_rdy  [2];
  logic       m_chg  [2];
  logic [3:0] m_prev [2];  // {ovc, err, rdy, pres}
  logic       m_en;
  logic [15:0] m_sw, m_cw;
  logic [7:0]  m_sl, m_cl;
  logic [3:0]  m_in;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin
        m_cnt[s] = 0; m_byp[s] = 1'b1; m_rdy[s] = 1'b0;
        m_chg[s] = 1'b0; m_prev[s] = 4'h0;
      end
      m_en = 1'b0;
    end else begin
      m_sw = (bus_we && bus_addr == SET_A) ? bus_wdata : 16'h0;
      m_cw = (bus_we && bus_addr == CLR_A) ? bus_wdata : 16'h0;
      for (int s = 0; s < 2; s++) begin
        m_sl = m_sw[s*8 +: 8];
        m_cl = m_cw[s*8 +: 8];
        m_in = {slot_ovc[s], slot_error[s], slot_ready[s], slot_present[s]};
        m_rdy[s] = slot_ready[s] && (m_cnt[s] == 0) && !m_sl[2];
        if (m_sl[2])          m_cnt[s] = RST_N_CYC;
        else if (m_cl[2])     m_cnt[s] = 0;
        else if (m_cnt[s] > 0) m_cnt[s] = m_cnt[s] - 1;
        if (m_sl[3])      m_byp[s] = 1'b1;
        else if (m_cl[3]) m_byp[s] = 1'b0;
        m_chg[s]  = (m_in != m_prev[s]) | (m_chg[s] & ~m_cl[0]);
        m_prev[s] = m_in;
      end
      if (m_sw[7])      m_en = 1'b1;
      else if (m_cw[7]) m_en = 1'b0;
    end
  end

  function automatic logic [15:0] exp_word();
    logic [15:0] w = 16'h0;
    for (int s = 0; s < 2; s++) begin
      w[s*8 +: 7] = {m_prev[s][3], m_prev[s][2], m_rdy[s], m_byp[s],
                     (m_cnt[s] != 0), m_prev[s][0], m_chg[s]};
    end
    w[7] = m_en;
    return w;
  endfunction

  function automatic logic [1:0] exp_status(int s);
    if (m_rdy[s])          return 2'b11;
    else if (m_prev[s][0]) return 2'b01;
    else                   return 2'b00;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%04h expected=0x%04h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    logic [15:0] w;
    #1;
    w = exp_word();
    if (bus_addr == SET_A || bus_addr == CLR_A) begin
      chk(bus_rdata == w, "R1 word", bus_rdata, w);
      chk({bus_rdata[12], bus_rdata[4]} == {m_rdy[1], m_rdy[0]}, "R5 ready bits",
          {14'h0, bus_rdata[12], bus_rdata[4]}, {14'h0, m_rdy[1], m_rdy[0]});
      chk({bus_rdata[8], bus_rdata[0]} == {m_chg[1], m_chg[0]}, "R7 change bits",
          {14'h0, bus_rdata[8], bus_rdata[0]}, {14'h0, m_chg[1], m_chg[0]});
      chk((bus_rdata & 16'h6262) == (w & 16'h6262), "R6 mirrors",
          bus_rdata & 16'h6262, w & 16'h6262);
    end else begin
      chk(bus_rdata == 16'h0, "R1 other address", bus_rdata, 16'h0);
    end
    chk(slot_bypass == {m_byp[1], m_byp[0]}, "R3 bypass",
        {14'h0, slot_bypass}, {14'h0, m_byp[1], m_byp[0]});
    chk(slot_reset == {(m_cnt[1] != 0), (m_cnt[0] != 0)}, "R4 reset pulse",
        {14'h0, slot_reset}, {14'h0, (m_cnt[1] != 0), (m_cnt[0] != 0)});
    chk(irq == (m_en & (m_chg[0] | m_chg[1])), "R8 irq",
        {15'h0, irq}, {15'h0, m_en & (m_chg[0] | m_chg[1])});
    chk(slot_status == {exp_status(1), exp_status(0)}, "R9 status",
        {12'h0, slot_status}, {12'h0, exp_status(1), exp_status(0)});
  endtask

  task automatic cyc();
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    cyc();
    bus_we = 1'b0; bus_addr = SET_A; bus_wdata = 16'h0;
    #1;
  endtask

  int n_hi;

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = SET_A; bus_wdata = 16'h0;
    slot_present = 2'b00; slot_ready = 2'b00; slot_error = 2'b00; slot_ovc = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) cyc();

    // R10 reset state
    chk(bus_rdata == 16'h0808, "R10 reset word", bus_rdata, 16'h0808);
    chk(slot_bypass == 2'b11 && slot_reset == 2'b00 && !irq, "R10 outputs",
        {slot_bypass, slot_reset, 11'h0, irq}, {2'b11, 2'b00, 12'h0});

    // R2 lane placement: clear slot 1 bypass only, reserved bit write
    wr(CLR_A, 16'h0800);
    chk(bus_rdata == 16'h0008 && slot_bypass == 2'b01, "R2 slot1 lane",
        bus_rdata, 16'h0008);
    wr(SET_A, 16'h8000);
    chk(bus_rdata[15] == 1'b0, "R2 reserved bit", bus_rdata, 16'h0008);

    // R6 writes to mirror bits ignored
    wr(SET_A, 16'h7272);
    chk((bus_rdata & 16'h7272) == 16'h0000, "R6 ignored set", bus_rdata, 16'h0008);

    // R4/R5 reset pulse with ready already high
    slot_ready[0] = 1'b1;
    cyc();
    cyc();
    wr(SET_A, 16'h0004);
    n_hi = 0;
    while (slot_reset[0] && n_hi < 50) begin
      chk(bus_rdata[4] == 1'b0, "R5 hidden in pulse", bus_rdata, bus_rdata & 16'hFFEF);
      n_hi++;
      cyc();
    end
    chk(n_hi == RST_N_CYC, "R4 pulse length", 16'(n_hi), 16'(RST_N_CYC));
    chk(bus_rdata[4] == 1'b0, "R5 edge of pulse end", bus_rdata, bus_rdata & 16'hFFEF);
    cyc();
    chk(bus_rdata[4] == 1'b1, "R5 ready after pulse", bus_rdata, bus_rdata | 16'h0010);
    chk(slot_status[1:0] == 2'b11, "R9 ready code", {12'h0, slot_status}, 16'h0003);

    // R4 abort through clear port
    wr(SET_A, 16'h0004);
    cyc();
    wr(CLR_A, 16'h0004);
    chk(slot_reset[0] == 1'b0, "R4 abort", {15'h0, slot_reset[0]}, 16'h0);

    // R7 clear and event in the same cycle
    chk(bus_rdata[0] == 1'b1, "R7 sticky", bus_rdata, bus_rdata | 16'h1);
    slot_present[0] = 1'b1;
    wr(CLR_A, 16'h0001);
    chk(bus_rdata[0] == 1'b1, "R7 event beats clear", bus_rdata, bus_rdata | 16'h1);
    wr(CLR_A, 16'h0001);
    chk(bus_rdata[0] == 1'b0, "R7 cleared", bus_rdata, bus_rdata & 16'hFFFE);

    // R8 interrupt enable and acknowledge
    wr(SET_A, 16'h0080);
    chk(!irq, "R8 no pending", {15'h0, irq}, 16'h0);
    slot_error[1] = 1'b1;
    cyc();
    chk(irq, "R8 raised", {15'h0, irq}, 16'h1);
    wr(CLR_A, 16'h0101);
    chk(!irq, "R8 ack", {15'h0, irq}, 16'h0);

    // Random phase with a fixed seed
    void'($urandom(32'h5EED_CA11));
    for (int i = 0; i < 3000; i++) begin
      for (int s = 0; s < 2; s++) begin
        if ($urandom_range(15) == 0) slot_present[s] = ~slot_present[s];
        if ($urandom_range(15) == 0) slot_ready[s]   = ~slot_ready[s];
        if ($urandom_range(31) == 0) slot_error[s]   = ~slot_error[s];
        if ($urandom_range(31) == 0) slot_ovc[s]     = ~slot_ovc[s];
      end
      if ($urandom_range(3) == 0) begin
        bus_we = 1'b1;
        case ($urandom_range(4))
          0, 1:    bus_addr = SET_A;
          2, 3:    bus_addr = CLR_A;
          default: bus_addr = OTH_A;
        endcase
        bus_wdata = 16'($urandom);
      end else begin
        bus_we = 1'b0;
        bus_addr = ($urandom_range(7) == 0) ? OTH_A : SET_A;
      end
      cyc();
    end
    bus_we = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule